// File: doc/BRIEF.md
# Multi-mode 16-bit down-counting timer

This block is a general purpose down-counter for a peripheral subsystem. A single 16-bit counter is shared by five operating modes: an interval timer, a pulse generator that toggles a pin on every underflow, an external event counter, and two capture modes that measure either the width of an input pulse or the period between two input edges. The counting rate comes from the bus clock, from fixed divisions of it, from one of two slow tick inputs passed through a power-of-two prescaler, or from the underflow pulse of a neighbouring timer.

Two compare channels watch the counter. Each has its own output pin whose resting level is programmable. When a channel matches, its pin swaps to the opposite level. On the next underflow the pin returns to its resting level. Event counting can be restricted to the periods when an enable pin sits at a chosen level. Software reaches everything through a small word-wide register port: seven addresses, writes taking effect on the clock edge, reads combinational.

The external input and the enable pin pass through a synchroniser before they are used. The cascade input and the tick inputs are taken as on-chip, single-cycle strobes.

Top module: `mm_down_timer`

## Requirements
- R1: After reset, the counter (address 0), compare A (address 1) and compare B (address 2) read 0xFFFF. The control word (address 3) reads 0, and all four output pins are low.
- R2: Control word bit 0 is the start bit, and bit 1 reads as the running status, which follows the start bit within two clocks. Writing control bit 2 as 1 clears the start bit and freezes the counter from the next edge. Writing bit 2 as 0 leaves counting controlled by bit 0 alone.
- R3: The source field, bits 6:4 of the mode word (address 4), sets the step rate. Code 0 steps every clock, code 1 steps every 8th clock, code 3 steps every 2nd clock, and codes 2 and 7 never step.
- R4: Source code 4 steps on the slow tick A and source code 6 on the slow tick B, each divided by 2^n, where n is the prescale field (mode bits 10:8). A source code counts only its own tick input.
- R5: Source code 5 steps once for each clock in which the cascade input is high.
- R6: A step taken at count 0 reloads the counter from the value last written to address 0. It also pulses the underflow output for that clock and sets control bit 5.
- R7: Mode code 1 (mode bits 2:0) toggles the pulse pin at every underflow when I/O word (address 5) bit 1 is set. The pin stays low while that bit is clear.
- R8: Mode code 2 steps on each rising edge of the synchronised external input. When mode bit 3 is set, it steps on both edges instead.
- R9: When I/O bit 2 is set, event steps count only while the synchronised enable pin equals I/O bit 3. In that setting, edges seen at the other level leave the counter unchanged.
- R10: Compare channel A uses I/O bits 4 (enable), 5 (pin enable) and 6 (resting level). Channel B uses bits 8, 9 and 10 for the same roles. A step that lands the counter on a channel's compare value sets the channel's flag (control bit 6 for A, bit 7 for B). The same step drives the channel's pin to the opposite of its resting level. The next underflow, or stopping the counter, returns the pin to its resting level, and a pin whose pin-enable bit is clear is low.
- R11: Mode code 3 steps only while the external input is high, or low when I/O bit 0 inverts it. At the end of that level, the counter value is captured to address 6, control bit 4 is set and the counter restarts from 0xFFFF. A level lasting W clocks captures 0xFFFF-W.
- R12: Mode code 4 steps on every source step and captures at each rising edge of the external input, reloading 0xFFFF. Two rising edges P clocks apart capture 0xFFFF-(P-1).
- R13: A control write clears each flag (bits 4 to 7) written as 0 and keeps each flag written as 1. If a flag is set in the same cycle, the set wins.
- R14: Mode codes 5 to 7 never step the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| lo_tick_a | input | 1 | Slow tick A (source 4) |
| lo_tick_b | input | 1 | Slow tick B (source 6) |
| casc_in | input | 1 | Underflow strobe from a neighbour timer (source 5) |
| ext_in | input | 1 | External event / measurement input |
| gate_in | input | 1 | Event enable pin |
| uf_pulse | output | 1 | One-clock underflow strobe |
| pulse_pin | output | 1 | Pulse-mode output |
| cmp_a_pin | output | 1 | Compare channel A output |
| cmp_b_pin | output | 1 | Compare channel B output |

## Verification
Properties check the following on every clock:
- a stopped counter stays frozen;
- an underflow reloads the counter and always raises the underflow flag;
- a capture restarts the count at 0xFFFF;
- a compare match always leaves its flag set;
- a forced stop clears the running status at once.

Some behaviours can only be shown by the bench's scenarios. These are the rates of each count source and prescale setting, exact capture values for random pulse widths and periods, and event totals with single, double and gated edges. They also include the duty cycles and resting levels of the compare pins, and the toggle rate of the pulse pin.

// File: rtl/mdt_pkg.sv
package mdt_pkg;
   typedef enum logic [2:0] {
      MD_TIMER  = 3'd0,
      MD_PULSE  = 3'd1,
      MD_EVENT  = 3'd2,
      MD_WIDTH  = 3'd3,
      MD_PERIOD = 3'd4
   } mdt_mode_e;

   localparam logic [2:0] A_COUNT = 3'd0;
   localparam logic [2:0] A_CMPA  = 3'd1;
   localparam logic [2:0] A_CMPB  = 3'd2;
   localparam logic [2:0] A_CTRL  = 3'd3;
   localparam logic [2:0] A_MODE  = 3'd4;
   localparam logic [2:0] A_IO    = 3'd5;
   localparam logic [2:0] A_CAPT  = 3'd6;

   localparam int CB_START = 0;
   localparam int CB_STAT  = 1;
   localparam int CB_STOP  = 2;
   localparam int CB_EDGE  = 4;
   localparam int CB_UNDF  = 5;
   localparam int CB_CMPA  = 6;
   localparam int CB_CMPB  = 7;

   typedef struct packed {
      logic en;
      logic oe;
      logic pol;
   } cmp_cfg_t;
endpackage

// File: rtl/mdt_tick_gen.sv
module mdt_tick_gen #(
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 8,
   parameter int PRE_W    = 3
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [2:0]       src,
   input  logic [PRE_W-1:0] pre,
   input  logic             lo_a,
   input  logic             lo_b,
   input  logic             casc,
   output logic             tick
);
   localparam int DIV_W  = $clog2(SLOW_DIV);
   localparam int FAST_W = $clog2(FAST_DIV);
   localparam int PCNT_W = (1 << PRE_W) - 1;

   if (SLOW_DIV < 2 || (SLOW_DIV & (SLOW_DIV - 1)) != 0) begin : g_bad_slow
      $error("SLOW_DIV must be a power of two of at least 2");
   end
   if (FAST_DIV < 2 || (FAST_DIV & (FAST_DIV - 1)) != 0 || FAST_DIV > SLOW_DIV) begin : g_bad_fast
      $error("FAST_DIV must be a power of two between 2 and SLOW_DIV");
   end

   logic [DIV_W-1:0] div_q;
   logic             fast_t, slow_t;
   logic [1:0]       raw_in, pre_tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   div_q <= '0;
      else if (!run) div_q <= '0;
      else          div_q <= div_q + 1'b1;
   end

   assign fast_t = run && (div_q[FAST_W-1:0] == {FAST_W{1'b1}});
   assign slow_t = run && (div_q == {DIV_W{1'b1}});
   assign raw_in = {lo_b, lo_a};

   for (genvar g = 0; g < 2; g++) begin : g_pre
      logic [PCNT_W-1:0] pc_q;
      logic [PCNT_W-1:0] mask;
      logic              wrap;
      assign mask = PCNT_W'((32'd1 << pre) - 32'd1);
      assign wrap = ((pc_q & mask) == mask);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         pc_q <= '0;
         else if (!run)      pc_q <= '0;
         else if (raw_in[g]) pc_q <= wrap ? '0 : pc_q + 1'b1;
      end
      assign pre_tick[g] = run && raw_in[g] && wrap;
   end

   always_comb begin
      case (src)
         3'd0:    tick = run;
         3'd1:    tick = slow_t;
         3'd3:    tick = fast_t;
         3'd4:    tick = pre_tick[0];
         3'd5:    tick = run && casc;
         3'd6:    tick = pre_tick[1];
         default: tick = 1'b0;
      endcase
   end
endmodule

// File: rtl/mdt_in_cond.sv
module mdt_in_cond #(
   parameter int SYNC = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ext_in,
   input  logic gate_in,
   input  logic invert,
   output logic lvl,
   output logic rise,
   output logic fall,
   output logic gate_lvl
);
   if (SYNC < 2) begin : g_bad_sync
      $error("SYNC must be at least 2");
   end

   logic [SYNC-1:0] s_ext, s_gate;
   logic            prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_ext  <= '0;
         s_gate <= '0;
         prev_q <= 1'b0;
      end else begin
         s_ext  <= {s_ext[SYNC-2:0], ext_in};
         s_gate <= {s_gate[SYNC-2:0], gate_in};
         prev_q <= lvl;
      end
   end

   assign lvl      = s_ext[SYNC-1] ^ invert;
   assign rise     = lvl & ~prev_q;
   assign fall     = ~lvl & prev_q;
   assign gate_lvl = s_gate[SYNC-1];
endmodule

// File: rtl/mdt_core.sv
module mdt_core
   import mdt_pkg::*;
#(
   parameter int CW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run_i,
   input  logic [2:0]    mode_i,
   input  logic          src_tick_i,
   input  logic          lvl_i,
   input  logic          rise_i,
   input  logic          fall_i,
   input  logic          both_i,
   input  logic          gate_en_i,
   input  logic          gate_sel_i,
   input  logic          gate_lvl_i,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   input  logic [CW-1:0] reload_i,
   input  logic [CW-1:0] cmp_a_i,
   input  logic [CW-1:0] cmp_b_i,
   input  cmp_cfg_t      cfg_a_i,
   input  cmp_cfg_t      cfg_b_i,
   input  logic          pulse_oe_i,
   output logic [CW-1:0] cnt_o,
   output logic [CW-1:0] capt_o,
   output logic          uf_o,
   output logic          cap_o,
   output logic          match_a_o,
   output logic          match_b_o,
   output logic          pulse_pin_o,
   output logic          pin_a_o,
   output logic          pin_b_o
);
   localparam logic [CW-1:0] TOP_VAL = {CW{1'b1}};

   logic          gate_ok, edge_ev, step, step_q;
   logic [CW-1:0] cnt_q, capt_q, cnt_next;
   logic          pulse_q;

   assign gate_ok = !gate_en_i || (gate_lvl_i == gate_sel_i);
   assign edge_ev = (rise_i || (both_i && fall_i)) && gate_ok;

   always_comb begin
      case (mode_i)
         MD_TIMER, MD_PULSE, MD_PERIOD: step = src_tick_i;
         MD_EVENT:                      step = edge_ev;
         MD_WIDTH:                      step = src_tick_i & lvl_i;
         default:                       step = 1'b0;
      endcase
   end

   assign cap_o    = run_i && (((mode_i == MD_WIDTH) && fall_i) || ((mode_i == MD_PERIOD) && rise_i));
   assign step_q   = run_i && step && !cap_o;
   assign uf_o     = step_q && (cnt_q == '0);
   assign cnt_next = uf_o ? reload_i : cnt_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= TOP_VAL;
         capt_q <= '0;
      end else begin
         if (load_i)      cnt_q <= load_val_i;
         else if (cap_o)  cnt_q <= TOP_VAL;
         else if (step_q) cnt_q <= cnt_next;
         if (cap_o) capt_q <= cnt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            pulse_q <= 1'b0;
      else if (!run_i)                       pulse_q <= 1'b0;
      else if (uf_o && (mode_i == MD_PULSE)) pulse_q <= ~pulse_q;
   end

   logic [CW-1:0] cmp_v [2];
   cmp_cfg_t      cfg_v [2];
   logic [1:0]    match_v, pin_v;
   assign cmp_v[0] = cmp_a_i;
   assign cmp_v[1] = cmp_b_i;
   assign cfg_v[0] = cfg_a_i;
   assign cfg_v[1] = cfg_b_i;

   for (genvar c = 0; c < 2; c++) begin : g_cmp
      logic out_q;
      assign match_v[c] = cfg_v[c].en && step_q && !uf_o && (cnt_next == cmp_v[c]);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                out_q <= 1'b0;
         else if (!run_i || uf_o)   out_q <= cfg_v[c].pol;
         else if (match_v[c])       out_q <= ~cfg_v[c].pol;
      end
      assign pin_v[c] = cfg_v[c].oe & out_q;
   end

   assign cnt_o       = cnt_q;
   assign capt_o      = capt_q;
   assign match_a_o   = match_v[0];
   assign match_b_o   = match_v[1];
   assign pin_a_o     = pin_v[0];
   assign pin_b_o     = pin_v[1];
   assign pulse_pin_o = pulse_oe_i & pulse_q;

   // R2
   frozen_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !load_i) |=> $stable(cnt_q));
   // R6
   uf_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_o && !load_i) |=> (cnt_q == $past(reload_i)));
   // R11
   capture_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_o && !load_i) |=> (cnt_q == TOP_VAL));
endmodule

// File: rtl/mm_down_timer.sv
module mm_down_timer
   import mdt_pkg::*;
#(
   parameter int CW       = 16,
   parameter int FAST_DIV = 2,
   parameter int SLOW_DIV = 8,
   parameter int PRE_W    = 3,
   parameter int SYNC     = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_addr,
   input  logic [CW-1:0] reg_wdata,
   output logic [CW-1:0] reg_rdata,
   input  logic          lo_tick_a,
   input  logic          lo_tick_b,
   input  logic          casc_in,
   input  logic          ext_in,
   input  logic          gate_in,
   output logic          uf_pulse,
   output logic          pulse_pin,
   output logic          cmp_a_pin,
   output logic          cmp_b_pin
);
   localparam int PRE_LSB = 8;

   if (CW < PRE_LSB + PRE_W || CW < 11) begin : g_bad_cw
      $error("CW too narrow for the mode and I/O fields");
   end

   logic [CW-1:0]    reload_q, cmpa_q, cmpb_q, cnt, capt;
   logic             start_q, run_q;
   logic             f_edge, f_undf, f_cmpa, f_cmpb;
   logic [2:0]       mode_q, src_q;
   logic             both_q;
   logic [PRE_W-1:0] pre_q;
   logic             inv_q, poe_q, gen_q, ghi_q;
   cmp_cfg_t         cfg_a_q, cfg_b_q;

   logic wr_ctrl, stop_wr, load;
   logic src_tick, lvl, rise, fall, gate_lvl;
   logic uf, cap, match_a, match_b;

   assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
   assign stop_wr = wr_ctrl && reg_wdata[CB_STOP];
   assign load    = reg_we && (reg_addr == A_COUNT);

   function automatic logic flag_nxt(input logic cur, input logic set, input logic clr);
      return set | (cur & ~clr);
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '1;
         cmpa_q   <= '1;
         cmpb_q   <= '1;
         start_q  <= 1'b0;
         run_q    <= 1'b0;
         f_edge   <= 1'b0;
         f_undf   <= 1'b0;
         f_cmpa   <= 1'b0;
         f_cmpb   <= 1'b0;
         mode_q   <= '0;
         src_q    <= '0;
         both_q   <= 1'b0;
         pre_q    <= '0;
         inv_q    <= 1'b0;
         poe_q    <= 1'b0;
         gen_q    <= 1'b0;
         ghi_q    <= 1'b0;
         cfg_a_q  <= '0;
         cfg_b_q  <= '0;
      end else begin
         run_q  <= stop_wr ? 1'b0 : start_q;
         if (wr_ctrl) start_q <= reg_wdata[CB_START] & ~reg_wdata[CB_STOP];
         f_edge <= flag_nxt(f_edge, cap,     wr_ctrl & ~reg_wdata[CB_EDGE]);
         f_undf <= flag_nxt(f_undf, uf,      wr_ctrl & ~reg_wdata[CB_UNDF]);
         f_cmpa <= flag_nxt(f_cmpa, match_a, wr_ctrl & ~reg_wdata[CB_CMPA]);
         f_cmpb <= flag_nxt(f_cmpb, match_b, wr_ctrl & ~reg_wdata[CB_CMPB]);
         if (reg_we) begin
            case (reg_addr)
               A_COUNT: reload_q <= reg_wdata;
               A_CMPA:  cmpa_q   <= reg_wdata;
               A_CMPB:  cmpb_q   <= reg_wdata;
               A_MODE: begin
                  mode_q <= reg_wdata[2:0];
                  both_q <= reg_wdata[3];
                  src_q  <= reg_wdata[6:4];
                  pre_q  <= reg_wdata[PRE_LSB +: PRE_W];
               end
               A_IO: begin
                  inv_q   <= reg_wdata[0];
                  poe_q   <= reg_wdata[1];
                  gen_q   <= reg_wdata[2];
                  ghi_q   <= reg_wdata[3];
                  cfg_a_q <= '{en: reg_wdata[4], oe: reg_wdata[5], pol: reg_wdata[6]};
                  cfg_b_q <= '{en: reg_wdata[8], oe: reg_wdata[9], pol: reg_wdata[10]};
               end
               default: ;
            endcase
         end
      end
   end

   mdt_tick_gen #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .PRE_W(PRE_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(run_q), .src(src_q), .pre(pre_q),
      .lo_a(lo_tick_a), .lo_b(lo_tick_b), .casc(casc_in), .tick(src_tick)
   );

   mdt_in_cond #(.SYNC(SYNC)) u_in (
      .clk(clk), .rst_n(rst_n), .ext_in(ext_in), .gate_in(gate_in), .invert(inv_q),
      .lvl(lvl), .rise(rise), .fall(fall), .gate_lvl(gate_lvl)
   );

   mdt_core #(.CW(CW)) u_core (
      .clk(clk), .rst_n(rst_n), .run_i(run_q), .mode_i(mode_q), .src_tick_i(src_tick),
      .lvl_i(lvl), .rise_i(rise), .fall_i(fall), .both_i(both_q),
      .gate_en_i(gen_q), .gate_sel_i(ghi_q), .gate_lvl_i(gate_lvl),
      .load_i(load), .load_val_i(reg_wdata), .reload_i(reload_q),
      .cmp_a_i(cmpa_q), .cmp_b_i(cmpb_q), .cfg_a_i(cfg_a_q), .cfg_b_i(cfg_b_q),
      .pulse_oe_i(poe_q), .cnt_o(cnt), .capt_o(capt), .uf_o(uf), .cap_o(cap),
      .match_a_o(match_a), .match_b_o(match_b), .pulse_pin_o(pulse_pin),
      .pin_a_o(cmp_a_pin), .pin_b_o(cmp_b_pin)
   );

   assign uf_pulse = uf;

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         A_COUNT: reg_rdata = cnt;
         A_CMPA:  reg_rdata = cmpa_q;
         A_CMPB:  reg_rdata = cmpb_q;
         A_CTRL:  reg_rdata[7:0] = {f_cmpb, f_cmpa, f_undf, f_edge, 1'b0, 1'b0, run_q, start_q};
         A_MODE:  begin
            reg_rdata[2:0] = mode_q;
            reg_rdata[3]   = both_q;
            reg_rdata[6:4] = src_q;
            reg_rdata[PRE_LSB +: PRE_W] = pre_q;
         end
         A_IO:    reg_rdata[10:0] = {cfg_b_q.pol, cfg_b_q.oe, cfg_b_q.en, 1'b0,
                                     cfg_a_q.pol, cfg_a_q.oe, cfg_a_q.en,
                                     ghi_q, gen_q, poe_q, inv_q};
         A_CAPT:  reg_rdata = capt;
         default: reg_rdata = '0;
      endcase
   end

   // R6
   uf_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf |=> f_undf);
   // R10
   match_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (match_a || match_b) |=> ((f_cmpa || !$past(match_a)) && (f_cmpb || !$past(match_b))));
   // R2
   stop_clears_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_wr |=> !run_q);
endmodule

// File: tb/sim_mm_down_timer.sv
`timescale 1ns/1ps
module sim_mm_down_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        lo_tick_a = 1'b0, lo_tick_b = 1'b0, casc_in = 1'b0, ext_in = 1'b0, gate_in = 1'b0;
   logic        uf_pulse, pulse_pin, cmp_a_pin, cmp_b_pin;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   mm_down_timer u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .lo_tick_a(lo_tick_a), .lo_tick_b(lo_tick_b), .casc_in(casc_in),
      .ext_in(ext_in), .gate_in(gate_in), .uf_pulse(uf_pulse), .pulse_pin(pulse_pin),
      .cmp_a_pin(cmp_a_pin), .cmp_b_pin(cmp_b_pin)
   );

   task automatic chk(input string req, input int got, input int exp);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s got=%0d exp=%0d", req, got, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      reg_addr = a;
      #1;
      v = int'(reg_rdata);
   endtask

   task automatic restart(input logic [15:0] mode_w, input logic [15:0] io_w, input logic [15:0] cnt_w);
      wr(3'd3, 16'h0004);
      wr(3'd4, mode_w);
      wr(3'd5, io_w);
      wr(3'd0, cnt_w);
      wr(3'd3, 16'h0001);
      tick(4);
   endtask

   // expected number of steps over a window, from the source rules
   function automatic int exp_steps(input int src, input int pre, input int win);
      case (src)
         0: return win;
         1: return win / 8;
         3: return win / 2;
         4, 6: return win >> pre;
         default: return 0;
      endcase
   endfunction

   function automatic int width_capt(input int w);
      return 16'hFFFF - w;
   endfunction

   function automatic int period_capt(input int p);
      return 16'hFFFF - (p - 1);
   endfunction

   task automatic measure_diff(input int win, output int d);
      int c1, c2;
      rd(3'd0, c1);
      tick(win);
      rd(3'd0, c2);
      d = (c1 - c2) & 16'hFFFF;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      int v, d, n, k, w, p, pre, hi_a, hi_b, tog, ufc;
      logic last;
      v = $urandom(32'd7741);
      tick(5);
      rst_n = 1'b1;
      tick(2);

      // R1 reset state
      rd(3'd0, v); chk("R1 counter", v, 16'hFFFF);
      rd(3'd1, v); chk("R1 cmpA", v, 16'hFFFF);
      rd(3'd2, v); chk("R1 cmpB", v, 16'hFFFF);
      rd(3'd3, v); chk("R1 control", v, 0);
      chk("R1 pins", int'({uf_pulse, pulse_pin, cmp_a_pin, cmp_b_pin}), 0);

      // R2 start and status
      wr(3'd0, 16'd30000);
      wr(3'd3, 16'h0001);
      tick(1);
      rd(3'd3, v); chk("R2 status after start", (v >> 1) & 1, 1);
      for (int t = 0; t < 3; t++) begin
         k = 16 + $urandom_range(0, 150);
         measure_diff(k, d); chk("R3 clock source steps", d, exp_steps(0, 0, k));
      end
      wr(3'd3, 16'h0004);
      rd(3'd3, v); chk("R2 forced stop status", v & 3, 0);
      measure_diff(20, d); chk("R2 frozen after stop", d, 0);
      wr(3'd3, 16'h0001);
      tick(3);
      measure_diff(16, d); chk("R2 stop written 0 no effect", d, 16);

      // R3 fixed divisions and invalid codes
      restart(16'h0010, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R3 div8", d, exp_steps(1, 0, 64));
      restart(16'h0030, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R3 div2", d, exp_steps(3, 0, 64));
      restart(16'h0020, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R3 code2 no step", d, 0);
      restart(16'h0070, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R3 code7 no step", d, 0);

      // R4 prescaled slow ticks
      lo_tick_a = 1'b1;
      pre = $urandom_range(0, 3);
      restart(16'(16'h0040 | (pre << 8)), 16'h0, 16'd30000);
      measure_diff(64, d); chk("R4 tick A prescaled", d, exp_steps(4, pre, 64));
      restart(16'h0360, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R4 tick B ignores tick A", d, 0);
      lo_tick_b = 1'b1;
      restart(16'h0360, 16'h0, 16'd30000);
      measure_diff(64, d); chk("R4 tick B div8", d, exp_steps(6, 3, 64));
      lo_tick_a = 1'b0; lo_tick_b = 1'b0;

      // R5 cascade
      restart(16'h0050, 16'h0, 16'd30000);
      n = 3 + $urandom_range(0, 17);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin
         casc_in = 1'b1; tick(1); casc_in = 1'b0; tick(1);
      end
      tick(2);
      rd(3'd0, v); chk("R5 cascade steps", (k - v) & 16'hFFFF, n);

      // R6 / R7 underflow and pulse output
      restart(16'h0001, 16'h0002, 16'd5);
      tick(8);
      ufc = 0; tog = 0; last = pulse_pin;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (uf_pulse) ufc++;
         if (pulse_pin != last) tog++;
         last = pulse_pin;
      end
      chk("R6 underflow pulses per reload", ufc, 10);
      chk("R7 pulse pin toggles", tog, 10);
      rd(3'd3, v); chk("R6 underflow flag", (v >> 5) & 1, 1);
      wr(3'd5, 16'h0000);
      tick(2);
      k = 0;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (pulse_pin) k++; end
      chk("R7 pin low when disabled", k, 0);

      // R13 flag keep and clear
      wr(3'd3, 16'h0024);
      rd(3'd3, v); chk("R13 flag kept by writing 1", (v >> 5) & 1, 1);
      wr(3'd3, 16'h0000);
      rd(3'd3, v); chk("R13 flag cleared by writing 0", (v >> 5) & 1, 0);

      // R10 compare outputs
      wr(3'd1, 16'd4);
      wr(3'd2, 16'd7);
      restart(16'h0000, 16'h0330, 16'd9);
      tick(8);
      hi_a = 0; hi_b = 0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (cmp_a_pin) hi_a++;
         if (cmp_b_pin) hi_b++;
      end
      chk("R10 channel A high time", hi_a, 50);
      chk("R10 channel B high time", hi_b, 80);
      rd(3'd3, v); chk("R10 match flags", (v >> 6) & 3, 3);
      wr(3'd3, 16'h0004);
      wr(3'd5, 16'h0370);
      tick(2);
      chk("R10 resting level A inverted", int'(cmp_a_pin), 1);
      chk("R10 resting level B normal", int'(cmp_b_pin), 0);
      wr(3'd5, 16'h0350);
      tick(2);
      chk("R10 pin A disabled", int'(cmp_a_pin), 0);

      // R8 event counting
      n = 2 + $urandom_range(0, 12);
      restart(16'h0002, 16'h0, 16'd1000);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin ext_in = 1'b1; tick(3); ext_in = 1'b0; tick(3); end
      tick(6);
      rd(3'd0, v); chk("R8 single edge", (k - v) & 16'hFFFF, n);
      restart(16'h000A, 16'h0, 16'd1000);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin ext_in = 1'b1; tick(3); ext_in = 1'b0; tick(3); end
      tick(6);
      rd(3'd0, v); chk("R8 both edges", (k - v) & 16'hFFFF, 2 * n);

      // R9 gating
      gate_in = 1'b0;
      restart(16'h0002, 16'h000C, 16'd1000);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin ext_in = 1'b1; tick(3); ext_in = 1'b0; tick(3); end
      tick(6);
      rd(3'd0, v); chk("R9 blocked at wrong level", (k - v) & 16'hFFFF, 0);
      gate_in = 1'b1;
      tick(4);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin ext_in = 1'b1; tick(3); ext_in = 1'b0; tick(3); end
      tick(6);
      rd(3'd0, v); chk("R9 counted at high level", (k - v) & 16'hFFFF, n);
      gate_in = 1'b0;
      restart(16'h0002, 16'h0004, 16'd1000);
      rd(3'd0, k);
      for (int i = 0; i < n; i++) begin ext_in = 1'b1; tick(3); ext_in = 1'b0; tick(3); end
      tick(6);
      rd(3'd0, v); chk("R9 counted at low level", (k - v) & 16'hFFFF, n);

      // R11 width measurement
      w = 5 + $urandom_range(0, 300);
      restart(16'h0003, 16'h0, 16'hFFFF);
      ext_in = 1'b1; tick(w); ext_in = 1'b0; tick(6);
      rd(3'd6, v); chk("R11 width capture", v, width_capt(w));
      rd(3'd0, v); chk("R11 restart at top", v, 16'hFFFF);
      rd(3'd3, v); chk("R11 edge flag", (v >> 4) & 1, 1);
      wr(3'd3, 16'h0004);
      ext_in = 1'b1;
      tick(4);
      w = 5 + $urandom_range(0, 300);
      restart(16'h0003, 16'h0001, 16'hFFFF);
      ext_in = 1'b0; tick(w); ext_in = 1'b1; tick(6);
      rd(3'd6, v); chk("R11 inverted width capture", v, width_capt(w));
      wr(3'd3, 16'h0004);
      ext_in = 1'b0;
      tick(4);

      // R12 period measurement
      p = 10 + $urandom_range(0, 300);
      restart(16'h0004, 16'h0, 16'hFFFF);
      ext_in = 1'b1; tick(2); ext_in = 1'b0; tick(p - 2);
      ext_in = 1'b1; tick(2); ext_in = 1'b0; tick(6);
      rd(3'd6, v); chk("R12 period capture", v, period_capt(p));

      // R14 prohibited modes
      restart(16'h0005, 16'h0, 16'd30000);
      measure_diff(32, d); chk("R14 mode 5 no step", d, 0);
      restart(16'h0007, 16'h0, 16'd30000);
      measure_diff(32, d); chk("R14 mode 7 no step", d, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule